// File: doc/BRIEF.md
# Boot Memory Alias Decoder

This block sits between a processor fetch bus and two behavioural flash banks and decides which bank answers each read. Bank 0 holds the user image and bank 1 holds the loader. The low boot window, a bank-sized region starting at address 0, is an alias. It shows the user bank or the loader bank, depending on a boot strap and on a check of the user image made after reset. Both banks can also be read at their own fixed direct addresses, so the vector fetched at address 0 can point straight at the direct copy of the same code.

When reset is released, a small state machine takes a snapshot of the strap. It then reads the first `CHECK_WORDS` words of the user bank. If every one of those words is all ones (erased flash), boot-window reads go to the loader bank whatever the strap says. The scan is finished before the first processor read is accepted. Read requests made while the scan runs are dropped, and `busy_o` is high for that time.

The states are `ST_LATCH`, `ST_SCAN` and `ST_READY`. `ST_LATCH` always goes to `ST_SCAN`. `ST_SCAN` stays in `ST_SCAN` until the last checked word has been read, then goes to `ST_READY`. `ST_READY` holds until the next reset. An unknown encoding falls back to `ST_LATCH`.

Top module: `boot_alias_decoder`

## Requirements
- R1: In `ST_READY`, a read inside the boot window (address bits 31..8 all zero) returns word `addr[7:2]` of bank 0 when the latched strap is 0 and the user image is not empty, and of bank 1 when the latched strap is 1. Word i of bank b holds `((0xA0+b)<<24) | i`, except that user-bank words below `USER_ERASED` hold all ones.
- R2: A read in the direct region (address bits 31..25 equal to 0b0000100 and bits 23..8 zero) returns word `addr[7:2]` of the bank given by address bit 24.
- R3: Any word reached through the boot window reads the same value at the direct address of the bank currently mapped to the window.
- R4: When all of the first `CHECK_WORDS` (4) user-bank words are all ones, boot-window reads return loader-bank data for either strap value. If only some of those words are erased, no redirect takes place.
- R5: The strap is sampled on the first clock edge after reset release. Later strap changes do not alter the boot-window mapping until the next reset.
- R6: After reset release, `busy_o` stays high for exactly `CHECK_WORDS`+1 rising edges and then stays low. A request made while `busy_o` is high produces no `rd_valid_o`.
- R7: A request accepted at a rising edge raises `rd_valid_o` for exactly the following cycle, with its data. Back-to-back requests are each answered one cycle later.
- R8: A read outside both the boot window and the direct region returns data 0 with `rd_valid_o` and `rd_err_o` both high.
- R9: During reset, `rd_valid_o`, `rd_err_o` and `rd_data_o` are 0 and `busy_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_i | input | 1 | Boot strap: 0 maps the user bank to the boot window, 1 maps the loader bank |
| rd_req_i | input | 1 | Read request, one word per cycle |
| rd_addr_i | input | ADDR_W | Byte address of the read |
| rd_data_o | output | DATA_W | Read data, registered |
| rd_valid_o | output | 1 | High for one cycle per accepted read |
| rd_err_o | output | 1 | Read hit no mapped region |
| busy_o | output | 1 | High while the post-reset image check runs |

## Verification
The hardest case to reach from the ports is the empty-image redirect. The flash contents are fixed at elaboration, so the bench cannot erase the user bank at run time. It therefore builds three copies of the decoder, with zero, all four and three of the checked words erased. All three run in lockstep under both strap values. A boot-window sweep then shows whether the window landed on the loader. The other hard case is the window between reset release and the end of the scan. The bench holds a boot-window request high through every busy cycle and counts the edges until `busy_o` drops.

// File: rtl/boot_alias_pkg.sv
package boot_alias_pkg;

    // Post-reset remap controller states
    typedef enum logic [1:0] {
        ST_LATCH = 2'd0,
        ST_SCAN  = 2'd1,
        ST_READY = 2'd2
    } remap_state_e;

    // Address regions seen by the read path
    typedef enum logic [1:0] {
        RG_BOOT   = 2'd0,
        RG_DIRECT = 2'd1,
        RG_NONE   = 2'd2
    } region_e;

endpackage

// File: rtl/boot_flash_bank.sv
module boot_flash_bank #(
    parameter int DATA_W       = 32,
    parameter int AW           = 6,
    parameter int BANK_ID      = 0,
    parameter int ERASED_WORDS = 0
) (
    input  logic [AW-1:0]     idx_i,
    output logic [DATA_W-1:0] word_o
);
    // Behavioural flash content: a bank marker in the top byte, index below
    localparam logic [DATA_W-1:0] MARKER = DATA_W'(8'hA0 + BANK_ID) << (DATA_W - 8);

    always_comb begin
        if (int'(idx_i) < ERASED_WORDS) begin
            word_o = '1;
        end else begin
            word_o = MARKER | DATA_W'(idx_i);
        end
    end
endmodule

// File: rtl/boot_addr_decode.sv
module boot_addr_decode
    import boot_alias_pkg::*;
#(
    parameter int                ADDR_W      = 32,
    parameter int                BYTE_AW     = 8,
    parameter int                SEL_BIT     = 24,
    parameter logic [ADDR_W-1:0] DIRECT_BASE = 32'h0800_0000
) (
    input  logic [ADDR_W-1:0]  addr_i,
    output region_e            region_o,
    output logic               bank_o,
    output logic [BYTE_AW-3:0] idx_o
);
    logic in_boot;
    logic in_direct;
    logic unused_lsb;

    assign unused_lsb = ^addr_i[1:0];

    always_comb begin
        in_boot   = (addr_i[ADDR_W-1:BYTE_AW] == '0);
        in_direct = (addr_i[ADDR_W-1:SEL_BIT+1] == DIRECT_BASE[ADDR_W-1:SEL_BIT+1]) &&
                    (addr_i[SEL_BIT-1:BYTE_AW] == '0);
        if (in_boot) begin
            region_o = RG_BOOT;
        end else if (in_direct) begin
            region_o = RG_DIRECT;
        end else begin
            region_o = RG_NONE;
        end
        bank_o = addr_i[SEL_BIT];
        idx_o  = addr_i[BYTE_AW-1:2];
    end
endmodule

// File: rtl/boot_remap_fsm.sv
module boot_remap_fsm
    import boot_alias_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int AW          = 6,
    parameter int CHECK_WORDS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strap_i,
    input  logic [DATA_W-1:0] scan_word_i,
    output logic [AW-1:0]     scan_idx_o,
    output logic              busy_o,
    output logic              boot_bank_o
);
    localparam int             CNT_W = $clog2(CHECK_WORDS) + 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CHECK_WORDS - 1);

    remap_state_e     state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             ones_q;
    logic             strap_q;

    // Next-state logic
    always_comb begin
        unique case (state_q)
            ST_LATCH: state_d = ST_SCAN;
            ST_SCAN:  state_d = (cnt_q == LAST) ? ST_READY : ST_SCAN;
            ST_READY: state_d = ST_READY;
            default:  state_d = ST_LATCH;
        endcase
    end

    // State register with the scan bookkeeping it owns
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_LATCH;
            cnt_q   <= '0;
            ones_q  <= 1'b1;
            strap_q <= 1'b0;
        end else begin
            state_q <= state_d;
            unique case (state_q)
                ST_LATCH: begin
                    strap_q <= strap_i;
                    cnt_q   <= '0;
                    ones_q  <= 1'b1;
                end
                ST_SCAN: begin
                    ones_q <= ones_q & (&scan_word_i);
                    cnt_q  <= cnt_q + 1'b1;
                end
                default: begin
                end
            endcase
        end
    end

    // Outputs
    always_comb begin
        busy_o      = (state_q != ST_READY);
        scan_idx_o  = AW'(cnt_q);
        boot_bank_o = strap_q | ones_q;
    end

    // R5: once ready, the snapshot of strap and scan result never moves
    a_r5_snapshot_held: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_READY) |=> ($stable(strap_q) && $stable(ones_q)));

    // R4: a checked word that is not all ones rules out the redirect
    a_r4_not_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SCAN && scan_word_i != '1) |=> !ones_q);

    // R6: the scan never runs past the last checked word
    a_r6_scan_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SCAN) |-> (cnt_q <= LAST));
endmodule

// File: rtl/boot_alias_decoder.sv
module boot_alias_decoder
    import boot_alias_pkg::*;
#(
    parameter int                ADDR_W      = 32,
    parameter int                DATA_W      = 32,
    parameter int                BANK_AW     = 6,
    parameter int                CHECK_WORDS = 4,
    parameter int                SEL_BIT     = 24,
    parameter logic [ADDR_W-1:0] DIRECT_BASE = 32'h0800_0000,
    parameter int                USER_ERASED = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strap_i,
    input  logic              rd_req_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              rd_valid_o,
    output logic              rd_err_o,
    output logic              busy_o
);
    localparam int BYTE_AW   = BANK_AW + 2;
    localparam int NUM_BANKS = 2;

    region_e            region;
    logic               dec_bank;
    logic [BANK_AW-1:0] rd_idx;
    logic [BANK_AW-1:0] scan_idx;
    logic               boot_bank;
    logic               sel_bank;
    logic               accept;

    logic [BANK_AW-1:0] bank_idx  [NUM_BANKS];
    logic [DATA_W-1:0]  bank_word [NUM_BANKS];

    boot_addr_decode #(
        .ADDR_W     (ADDR_W),
        .BYTE_AW    (BYTE_AW),
        .SEL_BIT    (SEL_BIT),
        .DIRECT_BASE(DIRECT_BASE)
    ) u_dec (
        .addr_i  (rd_addr_i),
        .region_o(region),
        .bank_o  (dec_bank),
        .idx_o   (rd_idx)
    );

    boot_remap_fsm #(
        .DATA_W     (DATA_W),
        .AW         (BANK_AW),
        .CHECK_WORDS(CHECK_WORDS)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .strap_i    (strap_i),
        .scan_word_i(bank_word[0]),
        .scan_idx_o (scan_idx),
        .busy_o     (busy_o),
        .boot_bank_o(boot_bank)
    );

    // Bank 0 is the user bank: the scanner owns its port while busy
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        if (b == 0) begin : g_user
            assign bank_idx[b] = busy_o ? scan_idx : rd_idx;
        end else begin : g_loader
            assign bank_idx[b] = rd_idx;
        end
        boot_flash_bank #(
            .DATA_W      (DATA_W),
            .AW          (BANK_AW),
            .BANK_ID     (b),
            .ERASED_WORDS((b == 0) ? USER_ERASED : 0)
        ) u_flash (
            .idx_i (bank_idx[b]),
            .word_o(bank_word[b])
        );
    end

    always_comb begin
        sel_bank = (region == RG_BOOT) ? boot_bank : dec_bank;
        accept   = rd_req_i && !busy_o;
    end

    // Registered read return: one-cycle latency
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_valid_o <= 1'b0;
            rd_err_o   <= 1'b0;
            rd_data_o  <= '0;
        end else begin
            rd_valid_o <= accept;
            rd_err_o   <= accept && (region == RG_NONE);
            rd_data_o  <= (accept && region != RG_NONE) ? bank_word[sel_bank] : '0;
        end
    end

    // R7: an accepted request is answered in the next cycle
    a_r7_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_i && !busy_o) |=> rd_valid_o);

    // R6/R7: no answer without an accepted request
    a_r6_no_valid_when_held: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o || !rd_req_i) |=> !rd_valid_o);

    // R8: an error reply carries zero data and is valid
    a_r8_err_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rd_err_o |-> (rd_valid_o && rd_data_o == '0));

    // R6: once the check is done it stays done
    a_r6_busy_stays_low: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |=> !busy_o);
endmodule

// File: tb/tb_boot_alias_decoder.sv
module tb_boot_alias_decoder;
    localparam int CW = 4;
    localparam int NU = 3;
    localparam int ERZ [NU] = '{0, 4, 3};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        strap = 1'b0;
    logic        req = 1'b0;
    logic [31:0] addr = '0;

    logic [31:0] dq [NU];
    logic        vq [NU];
    logic        eq [NU];
    logic        bq [NU];

    int vectors = 0;
    int fails = 0;
    bit done = 0;

    always #4 clk = ~clk;

    for (genvar u = 0; u < NU; u++) begin : g_unit
        boot_alias_decoder #(.USER_ERASED(ERZ[u])) dut (
            .clk       (clk),
            .rst_n     (rst_n),
            .strap_i   (strap),
            .rd_req_i  (req),
            .rd_addr_i (addr),
            .rd_data_o (dq[u]),
            .rd_valid_o(vq[u]),
            .rd_err_o  (eq[u]),
            .busy_o    (bq[u])
        );
    end

    function automatic logic [31:0] word_of(int bank, int idx, int erz);
        if (bank == 0 && idx < erz) return 32'hFFFF_FFFF;
        return ((32'hA0 + 32'(bank)) << 24) | 32'(idx);
    endfunction

    function automatic void exp_rd(input logic [31:0] a, input logic s, input int erz,
                                   output logic err, output logic [31:0] data);
        int bb;
        bb = (s || erz >= CW) ? 1 : 0;
        err = 1'b0;
        if (a[31:8] == 24'h0) data = word_of(bb, int'(a[7:2]), erz);
        else if (a[31:25] == 7'h04 && a[23:8] == 16'h0) data = word_of(int'(a[24]), int'(a[7:2]), erz);
        else begin
            err = 1'b1;
            data = '0;
        end
    endfunction

    task automatic chk(input string tag, input string what, input int u,
                       input logic [31:0] got, input logic [31:0] exp);
        vectors++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s unit%0d %s: got %h expected %h", tag, u, what, got, exp);
        end
    endtask

    function automatic string tag_of(logic [31:0] a, int erz);
        if (a[31:8] == 24'h0) return (erz > 0) ? "R4" : "R1";
        if (a[31:25] == 7'h04 && a[23:8] == 16'h0) return "R2";
        return "R8";
    endfunction

    task automatic check_reply(input logic [31:0] a, input logic s);
        for (int u = 0; u < NU; u++) begin
            logic e;
            logic [31:0] d;
            string t;
            exp_rd(a, s, ERZ[u], e, d);
            t = tag_of(a, ERZ[u]);
            chk("R7", "valid", u, 32'(vq[u]), 32'd1);
            chk(t, "err", u, 32'(eq[u]), 32'(e));
            chk(t, "data", u, dq[u], d);
        end
    endtask

    task automatic do_read(input logic [31:0] a, input logic s);
        @(negedge clk);
        req = 1'b1;
        addr = a;
        @(negedge clk);
        req = 1'b0;
        check_reply(a, s);
    endtask

    task automatic run_reset(input logic s);
        @(negedge clk);
        rst_n = 1'b0;
        req = 1'b0;
        strap = s;
        repeat (3) @(negedge clk);
        for (int u = 0; u < NU; u++) begin
            chk("R9", "reset valid", u, 32'(vq[u]), 32'd0);
            chk("R9", "reset err", u, 32'(eq[u]), 32'd0);
            chk("R9", "reset data", u, dq[u], 32'd0);
            chk("R9", "reset busy", u, 32'(bq[u]), 32'd1);
        end
        rst_n = 1'b1;
        req = 1'b1;
        addr = 32'h0;
        for (int c = 1; c <= CW + 1; c++) begin
            @(negedge clk);
            for (int u = 0; u < NU; u++) begin
                chk("R6", "valid while busy", u, 32'(vq[u]), 32'd0);
                chk("R6", "busy length", u, 32'(bq[u]), (c < CW + 1) ? 32'd1 : 32'd0);
            end
        end
        req = 1'b0;
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        for (int si = 0; si < 2; si++) begin
            logic s;
            s = si[0];
            run_reset(s);
            // Full sweep of the boot window and both direct windows
            for (int i = 0; i < 64; i++) begin
                do_read(32'(i * 4), s);
                do_read(32'h0800_0000 + 32'(i * 4), s);
                do_read(32'h0900_0000 + 32'(i * 4), s);
            end
            // R8: unmapped addresses
            do_read(32'h0000_0100, s);
            do_read(32'h0800_0100, s);
            do_read(32'h0A00_0000, s);
            do_read(32'h0400_0000, s);
            do_read(32'hFFFF_FFFC, s);
            // R3: alias and direct copy agree
            for (int i = 0; i < 8; i++) begin
                logic [31:0] alias_d [NU];
                do_read(32'(i * 4), s);
                for (int u = 0; u < NU; u++) alias_d[u] = dq[u];
                for (int u = 0; u < NU; u++) begin
                    logic [31:0] da;
                    logic bb;
                    bb = s | (ERZ[u] >= CW);
                    @(negedge clk);
                    req = 1'b1;
                    addr = (bb ? 32'h0900_0000 : 32'h0800_0000) + 32'(i * 4);
                    @(negedge clk);
                    req = 1'b0;
                    da = dq[u];
                    chk("R3", "alias vs direct", u, da, alias_d[u]);
                end
            end
            // R5: strap flips after release have no effect
            strap = ~s;
            for (int i = 0; i < 8; i++) do_read(32'(i * 4), s);
            // R7: back-to-back requests
            for (int k = 0; k <= 8; k++) begin
                @(negedge clk);
                if (k > 0) check_reply(32'((k - 1) * 4), s);
                if (k < 8) begin
                    req = 1'b1;
                    addr = 32'((k * 4) % 256);
                end else req = 1'b0;
            end
            @(negedge clk);
            for (int u = 0; u < NU; u++) chk("R7", "single-cycle valid", u, 32'(vq[u]), 32'd0);
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule